// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block is the card-side control for a 16-input multiplexed analog input with a 12-bit converter. Software programs it through a byte-wide register port. It sets a scan window as a pair of first and last channel nibbles, stores a gain code for each channel, picks where conversion triggers come from, and turns the interrupt and DMA request on or off. Each accepted trigger starts one conversion on the current channel and then moves the channel pointer on. The pointer wraps from the last channel of the window back to the first.

The converter is modelled as a fixed latency of `CONV_CYCLES` clocks. When that latency ends, the sample on `adcData` is captured together with the 4-bit number of the channel it came from. The completion sets a sticky done flag, which drives the interrupt request when interrupts are enabled, and can fire a one-cycle DMA request. The pacer, the analog front end and the DMA controller are outside the block. The pacer arrives as a one-cycle tick and the external trigger as a level pin whose rising edge counts.

Register addresses: 0 is the result low byte on read and the software trigger on write. 1 is the result high byte on read and the gain write. 2 is the scan window. 8 is status on read and the done clear on write. 9 is control.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset no conversion is running. The done flag, the window, the control register and every gain are zero. `irqReq` and `dmaReq` are low.
- R2: A write to address 2 sets the last channel from data bits 7:4 and the first channel from bits 3:0. The next channel to convert becomes the first channel. Reading address 2 returns the same byte.
- R3: A write to address 1 stores data bits 3:0 as the gain of the channel held in the window's first-channel nibble. `muxGain` always shows the gain of the channel on `muxChan`.
- R4: Control bits 1:0 select the trigger source: 0 none, 1 software, 2 rising edge of `extTrig`, 3 a `pacerTick` pulse. A source that is not selected starts no conversion.
- R5: With software triggering selected, a write of any value to address 0 starts a conversion on the next channel.
- R6: The done flag sets and `convBusy` falls exactly `CONV_CYCLES` clocks after the clock edge that started the conversion.
- R7: The result word holds the channel tag in bits 3:0 and the 12-bit sample in bits 15:4. Address 0 reads bits 7:0 and address 1 reads bits 15:8.
- R8: When a conversion starts, the channel pointer moves to the first channel if it was on the last channel of the window. Otherwise it increments modulo 16 when `seMode` is high and modulo 8 when it is low. `muxChan` shows the converting channel while busy and the next channel otherwise.
- R9: Status (address 8) reads bit 7 busy, bit 6 `uniMode`, bit 5 `seMode`, bit 4 done, and bits 3:0 the next channel.
- R10: The done flag stays set across further conversions until a write of any value to address 8 clears it. A completion in the same cycle as a clear wins.
- R11: `irqReq` equals done AND control bit 7. `irqLine` shows control bits 6:4.
- R12: When control bit 2 is set, each completed conversion raises `dmaReq` for exactly one cycle, in the cycle after the done flag is set.
- R13: A trigger that arrives while a conversion is in progress is ignored. It neither restarts the conversion nor moves the channel pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Register address |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | 8 | Register write data |
| busRdData | output | 8 | Register read data (combinational on address) |
| extTrig | input | 1 | External trigger level, rising edge counts |
| pacerTick | input | 1 | One-cycle pacer pulse |
| seMode | input | 1 | 1 = 16 single-ended inputs, 0 = 8 differential |
| uniMode | input | 1 | Unipolar jumper state, reported in status |
| adcData | input | 12 | Converter sample, captured at completion |
| muxChan | output | 4 | Channel selected on the multiplexer |
| muxGain | output | 4 | Gain code for the selected channel |
| convBusy | output | 1 | Conversion in progress |
| irqReq | output | 1 | Interrupt request |
| irqLine | output | 3 | Interrupt line number from control |
| dmaReq | output | 1 | One-cycle DMA request per conversion |

## Verification
The bound checker watches every cycle. It checks that the DMA pulse lasts one cycle and only follows a conversion, that the done flag rises only when a conversion ends and falls only on a write to the status address, and that a busy period leaves the channel pointer untouched. Some behaviour depends on the order of events, and only the bench's scenarios show it. That covers the exact latency, the tag and sample bit layout, the wrap from the last channel to the first in both input modes, per-channel gain lookup, and the way each trigger source is accepted or ignored. A behavioural model in the bench follows every output cycle by cycle to catch any departure between those scenarios.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_RESULT_LO = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_RESULT_HI = 4'h1;
  localparam logic [ADDR_W-1:0] ADDR_WINDOW    = 4'h2;
  localparam logic [ADDR_W-1:0] ADDR_STATUS    = 4'h8;
  localparam logic [ADDR_W-1:0] ADDR_CTRL      = 4'h9;

  typedef enum logic [1:0] {
    TRIG_OFF   = 2'd0,
    TRIG_SOFT  = 2'd1,
    TRIG_EXT   = 2'd2,
    TRIG_PACER = 2'd3
  } trigSel_e;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic       winWr;
    logic       gainWr;
    logic       clrDone;
    logic       convStart;
    logic       convEnd;
    logic       busy;
    logic [7:0] wrData;
  } seqStrobes_t;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_scan_pkg::*;
#(
  parameter int CONV_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  input  logic              extTrig,
  input  logic              pacerTick,
  output seqStrobes_t       stb,
  output logic [7:0]        ctrlReg,
  output logic              dmaReq
);

  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             extPrev;
  logic             trigHit;
  trigSel_e         trigSel;

  assign trigSel = trigSel_e'(ctrlReg[1:0]);

  always_comb begin
    unique case (trigSel)
      TRIG_SOFT:  trigHit = busWrEn && (busAddr == ADDR_RESULT_LO);
      TRIG_EXT:   trigHit = extTrig && !extPrev;
      TRIG_PACER: trigHit = pacerTick;
      default:    trigHit = 1'b0;
    endcase
  end

  always_comb begin
    stb.winWr     = busWrEn && (busAddr == ADDR_WINDOW);
    stb.gainWr    = busWrEn && (busAddr == ADDR_RESULT_HI);
    stb.clrDone   = busWrEn && (busAddr == ADDR_STATUS);
    stb.convStart = trigHit && !busy;
    stb.convEnd   = busy && (cnt == '0);
    stb.busy      = busy;
    stb.wrData    = busWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      extPrev <= 1'b0;
      busy    <= 1'b0;
      cnt     <= '0;
      dmaReq  <= 1'b0;
    end else begin
      extPrev <= extTrig;
      dmaReq  <= stb.convEnd && ctrlReg[2];
      if (busWrEn && (busAddr == ADDR_CTRL)) ctrlReg <= busWrData;
      if (stb.convStart) begin
        busy <= 1'b1;
        cnt  <= CNT_LOAD;
      end else if (stb.convEnd) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int SAMPLE_W = 12,
  parameter int GAIN_W   = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  seqStrobes_t                stb,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [7:0]                 ctrlReg,
  input  logic [SAMPLE_W-1:0]        adcData,
  input  logic                       seMode,
  input  logic                       uniMode,
  output logic [7:0]                 busRdData,
  output logic [$clog2(NUM_CH)-1:0]  muxChan,
  output logic [GAIN_W-1:0]          muxGain,
  output logic                       doneFlag,
  output logic [$clog2(NUM_CH)-1:0]  nextChan
);

  localparam int CH_W  = $clog2(NUM_CH);
  localparam int RES_W = SAMPLE_W + CH_W;
  localparam logic [CH_W-1:0] MASK_SE   = CH_W'(NUM_CH - 1);
  localparam logic [CH_W-1:0] MASK_DIFF = CH_W'(NUM_CH / 2 - 1);

  logic [CH_W-1:0]     firstChan, lastChan, convChan, advChan, wrapMask;
  logic [RES_W-1:0]    resWord;
  logic [GAIN_W-1:0]   gainReg [NUM_CH];

  assign wrapMask = seMode ? MASK_SE : MASK_DIFF;
  assign advChan  = (nextChan == lastChan) ? firstChan
                                           : ((nextChan + 1'b1) & wrapMask);

  // per-channel gain storage
  for (genvar g = 0; g < NUM_CH; g++) begin : g_gain
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) gainReg[g] <= '0;
      else if (stb.gainWr && (firstChan == CH_W'(g)))
        gainReg[g] <= stb.wrData[GAIN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstChan <= '0;
      lastChan  <= '0;
      nextChan  <= '0;
      convChan  <= '0;
      resWord   <= '0;
      doneFlag  <= 1'b0;
    end else begin
      if (stb.convStart) begin
        convChan <= nextChan;
        nextChan <= advChan;
      end
      if (stb.winWr) begin
        firstChan <= stb.wrData[CH_W-1:0];
        lastChan  <= stb.wrData[4 +: CH_W];
        nextChan  <= stb.wrData[CH_W-1:0];
      end
      if (stb.convEnd) begin
        resWord  <= {adcData, convChan};
        doneFlag <= 1'b1;
      end else if (stb.clrDone) begin
        doneFlag <= 1'b0;
      end
    end
  end

  assign muxChan = stb.busy ? convChan : nextChan;
  assign muxGain = gainReg[muxChan];

  always_comb begin
    unique case (busAddr)
      ADDR_RESULT_LO: busRdData = resWord[7:0];
      ADDR_RESULT_HI: busRdData = resWord[15:8];
      ADDR_WINDOW:    busRdData = {lastChan, firstChan};
      ADDR_STATUS:    busRdData = {stb.busy, uniMode, seMode, doneFlag, nextChan};
      ADDR_CTRL:      busRdData = ctrlReg;
      default:        busRdData = 8'h00;
    endcase
  end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH      = 16,
  parameter int SAMPLE_W    = 12,
  parameter int GAIN_W      = 4,
  parameter int CONV_CYCLES = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [3:0]           busAddr,
  input  logic                 busWrEn,
  input  logic [7:0]           busWrData,
  output logic [7:0]           busRdData,
  input  logic                 extTrig,
  input  logic                 pacerTick,
  input  logic                 seMode,
  input  logic                 uniMode,
  input  logic [SAMPLE_W-1:0]  adcData,
  output logic [3:0]           muxChan,
  output logic [GAIN_W-1:0]    muxGain,
  output logic                 convBusy,
  output logic                 irqReq,
  output logic [2:0]           irqLine,
  output logic                 dmaReq
);

  seqStrobes_t stb;
  logic [7:0]  ctrlReg;
  logic        doneFlag;
  logic [3:0]  nextChan;

  adc_seq_ctrl #(.CONV_CYCLES(CONV_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .extTrig(extTrig), .pacerTick(pacerTick),
    .stb(stb), .ctrlReg(ctrlReg), .dmaReq(dmaReq)
  );

  adc_seq_datapath #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busAddr(busAddr), .ctrlReg(ctrlReg),
    .adcData(adcData), .seMode(seMode), .uniMode(uniMode),
    .busRdData(busRdData), .muxChan(muxChan), .muxGain(muxGain),
    .doneFlag(doneFlag), .nextChan(nextChan)
  );

  assign convBusy = stb.busy;
  assign irqReq   = doneFlag & ctrlReg[7];
  assign irqLine  = ctrlReg[6:4];

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk
  import adc_scan_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       busWrEn,
  input logic [3:0] busAddr,
  input logic       dmaReq,
  input logic       convBusy,
  input logic       doneFlag,
  input logic [3:0] nextChan
);

  assert_dma_single_R12: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |=> !dmaReq);

  assert_dma_after_conv_R12: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> $past(convBusy));

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !(busWrEn && busAddr == ADDR_STATUS)) |=> doneFlag);

  assert_done_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(doneFlag) |-> $past(busWrEn && busAddr == ADDR_STATUS));

  assert_done_from_conv_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> ($past(convBusy) && !convBusy));

  assert_busy_holds_chan_R13: assert property (@(posedge clk) disable iff (!rstN)
    (convBusy && !(busWrEn && busAddr == ADDR_WINDOW)) |=> (nextChan == $past(nextChan)));

endmodule

bind adc_scan_seq adc_scan_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .dmaReq(dmaReq), .convBusy(convBusy), .doneFlag(doneFlag), .nextChan(nextChan)
);

// File: tb/sim_adc_scan_seq.sv
module sim_adc_scan_seq;

  localparam int CONV = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic        extTrig = 1'b0;
  logic        pacerTick = 1'b0;
  logic        seMode = 1'b1;
  logic        uniMode = 1'b0;
  logic [11:0] adcData = '0;
  logic [3:0]  muxChan;
  logic [3:0]  muxGain;
  logic        convBusy;
  logic        irqReq;
  logic [2:0]  irqLine;
  logic        dmaReq;

  int compared = 0;
  int mismatched = 0;
  int dmaCount = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_scan_seq #(.CONV_CYCLES(CONV)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .extTrig(extTrig),
    .pacerTick(pacerTick), .seMode(seMode), .uniMode(uniMode),
    .adcData(adcData), .muxChan(muxChan), .muxGain(muxGain),
    .convBusy(convBusy), .irqReq(irqReq), .irqLine(irqLine), .dmaReq(dmaReq)
  );

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mBusy, mCnt, mCur, mConv, mFirst, mLast, mCtrl, mDone, mTag, mSamp, mDma, mExtPrev;
  int mGain[16];

  always @(posedge clk) begin
    int sel, mask, start, fin, nxt;
    if (!rstN) begin
      mBusy = 0; mCnt = 0; mCur = 0; mConv = 0; mFirst = 0; mLast = 0;
      mCtrl = 0; mDone = 0; mTag = 0; mSamp = 0; mDma = 0; mExtPrev = 0;
      for (int i = 0; i < 16; i++) mGain[i] = 0;
    end else begin
      sel = mCtrl & 3;
      start = 0;
      if (mBusy == 0) begin
        if (sel == 1) start = (busWrEn && busAddr == 0) ? 1 : 0;
        if (sel == 2) start = (extTrig && mExtPrev == 0) ? 1 : 0;
        if (sel == 3) start = pacerTick ? 1 : 0;
      end
      fin = (mBusy != 0 && mCnt == 0) ? 1 : 0;
      mask = seMode ? 15 : 7;
      nxt = (mCur == mLast) ? mFirst : ((mCur + 1) & mask);
      mDma = (fin != 0 && (mCtrl & 4) != 0) ? 1 : 0;
      if (fin != 0) begin
        mTag = mConv; mSamp = adcData; mDone = 1;
      end else if (busWrEn && busAddr == 8) mDone = 0;
      if (start != 0) begin
        mBusy = 1; mCnt = CONV - 1; mConv = mCur; mCur = nxt;
      end else if (fin != 0) mBusy = 0;
      else if (mBusy != 0) mCnt = mCnt - 1;
      if (busWrEn) begin
        if (busAddr == 1) mGain[mFirst] = busWrData & 15;
        if (busAddr == 2) begin
          mFirst = busWrData & 15; mLast = busWrData >> 4; mCur = mFirst;
        end
        if (busAddr == 9) mCtrl = busWrData;
      end
      mExtPrev = extTrig ? 1 : 0;
    end
  end

  function automatic int expRd();
    case (busAddr)
      4'h0: return ((mSamp & 15) << 4) | mTag;
      4'h1: return (mSamp >> 4) & 255;
      4'h2: return (mLast << 4) | mFirst;
      4'h8: return (mBusy << 7) | (int'(uniMode) << 6) | (int'(seMode) << 5) | (mDone << 4) | mCur;
      4'h9: return mCtrl;
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    int ch;
    if (rstN && !finished) begin
      ch = (mBusy != 0) ? mConv : mCur;
      chk("R9 busRdData", busRdData, expRd());
      chk("R8 muxChan", muxChan, ch);
      chk("R3 muxGain", muxGain, mGain[ch]);
      chk("R11 irqReq", irqReq, ((mCtrl >> 7) & mDone));
      chk("R11 irqLine", irqLine, (mCtrl >> 4) & 7);
      chk("R12 dmaReq", dmaReq, mDma);
      chk("R6 convBusy", convBusy, mBusy);
    end
  end

  always @(posedge clk) if (dmaReq) dmaCount++;

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    tick();
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input int exp, input string tag);
    busAddr = a;
    @(negedge clk);
    chk(tag, busRdData, exp);
    tick();
  endtask

  task automatic convWait();
    repeat (CONV + 2) tick();
  endtask

  task automatic pulsePacer();
    pacerTick = 1'b1; tick(); pacerTick = 1'b0;
  endtask

  initial begin
    #200000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int dmaBase;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    rd(4'h8, 8'h20, "R1 status after reset");
    rd(4'h2, 8'h00, "R1 window after reset");
    rd(4'h9, 8'h00, "R1 ctrl after reset");
    chk("R1 irqReq low", irqReq, 0);
    chk("R1 dmaReq low", dmaReq, 0);

    // R3 gain for channel 3, R2 window
    wr(4'h2, 8'h33);
    wr(4'h1, 8'h07);
    wr(4'h2, 8'h53);
    rd(4'h2, 8'h53, "R2 window readback");
    rd(4'h8, 8'h23, "R2 next channel is first");

    // control: soft trigger, dma, irq line 3, irq enable
    wr(4'h9, 8'hB5);
    chk("R11 irqLine", irqLine, 3);

    // R5/R6 software conversion on channel 3
    dmaBase = dmaCount;
    adcData = 12'hABC;
    wr(4'h0, 8'h99);
    busAddr = 4'h8;
    @(negedge clk);
    chk("R5 busy after sw write", busRdData, 8'hA4);
    chk("R8 muxChan during conversion", muxChan, 3);
    chk("R3 gain of channel 3", muxGain, 7);
    repeat (CONV - 1) @(negedge clk);
    chk("R6 not done one cycle early", busRdData, 8'hA4);
    @(negedge clk);
    chk("R6 done at latency", busRdData, 8'h34);
    chk("R11 irqReq with done", irqReq, 1);
    tick();
    tick();
    rd(4'h0, 8'hC3, "R7 result low byte");
    rd(4'h1, 8'hAB, "R7 result high byte");
    chk("R12 one dma pulse", dmaCount - dmaBase, 1);

    // R13 trigger while busy ignored
    dmaBase = dmaCount;
    adcData = 12'h123;
    wr(4'h0, 8'h00);
    tick();
    wr(4'h0, 8'h00);
    convWait();
    rd(4'h8, 8'h35, "R13 pointer advanced once");
    rd(4'h0, 8'h34, "R7 tag of channel 4");
    chk("R12 dma once for ignored retrigger", dmaCount - dmaBase, 1);

    // R8 wrap from last to first
    wr(4'h0, 8'h00);
    convWait();
    rd(4'h8, 8'h33, "R8 wrap to first channel");

    // R10 clear done
    wr(4'h8, 8'h5A);
    rd(4'h8, 8'h23, "R10 done cleared by status write");
    chk("R10 irqReq after clear", irqReq, 0);

    // R4 trigger disabled: sw write and pacer ignored
    wr(4'h9, 8'h80);
    wr(4'h0, 8'h00);
    pulsePacer();
    convWait();
    rd(4'h8, 8'h23, "R4 disabled source ignores triggers");

    // R4 external edge
    wr(4'h9, 8'h02);
    extTrig = 1'b1;
    repeat (3) tick();
    extTrig = 1'b0;
    convWait();
    rd(4'h8, 8'h34, "R4 ext edge gives one conversion");
    pulsePacer();
    wr(4'h0, 8'h00);
    convWait();
    rd(4'h8, 8'h34, "R4 pacer and sw ignored in ext mode");

    // R4 pacer
    wr(4'h9, 8'h03);
    pulsePacer();
    convWait();
    rd(4'h8, 8'h35, "R4 pacer tick converts");

    // R8 differential wrap modulo 8
    seMode = 1'b0;
    wr(4'h2, 8'h26);
    wr(4'h9, 8'h01);
    wr(4'h0, 8'h00);
    convWait();
    rd(4'h8, 8'h17, "R8 diff step 6 to 7");
    wr(4'h0, 8'h00);
    convWait();
    rd(4'h8, 8'h10, "R8 diff wrap 7 to 0");
    wr(4'h0, 8'h00);
    convWait();
    rd(4'h8, 8'h11, "R8 diff step 0 to 1");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule